// File: doc/BRIEF.md
# Per-Port PHY Link Mode Controller

This block looks after link bring-up and link monitoring for one switch port. A small control word selects one of four link modes and supplies static speed, duplex and flow-control settings, along with an asymmetric-pause bit. A sequencer reaches the external PHY through a request/acknowledge register-access port, and a serial management shifter sits behind that port. Depending on the mode, the sequencer programs the PHY's advertisement and control registers, or it only polls the PHY status register, or it stays quiet while the link is forced.

The block drives the resolved link state, speed, duplex and pause enables to the port's MAC. Whenever a poll finds that the link status has changed, it raises a sticky interrupt toward the host. A companion output tells the host whether the event was a link-up or a link-down. In poll-only mode the host can emulate negotiation in software. On a link-up interrupt it reads the PHY itself, switches the port to forced-up mode with the right static bits, and then returns it to poll-only mode. The static bits are ignored in poll-only mode, so the port keeps the settings it was forced to.

Top module: `phy_link_ctl`

## Requirements
- R1: After reset, link_up, irq, irq_up, mdio_req, speed_10, pause_rx_en and pause_tx_en are 0, and full_dpx is 1.
- R2: In mode 2'b00, the block first writes PHY register 4 with 16'h01E1, with bit 10 set to the inverse of cfg_fc_off. It then writes PHY register 0 with 16'h1200, and after that it only polls.
- R3: Each poll reads PHY register 1 twice in a row. The link status is bit 2 of the second read, so a drop that the PHY has latched and since recovered from does not change link_up. Polls start again POLL_CYCLES cycles after the previous poll ends.
- R4: In mode 2'b00, after a poll that finds the link up, PHY register 5 is read. The outputs then take the best mode that both sides share, in the order 100 full (bit 8), 100 half (bit 7), 10 full (bit 6), 10 half. pause_rx_en is 1 only when register 5 bit 10 is set and pause was advertised.
- R5: In mode 2'b01, the block issues no PHY writes and reads only register 1. While in this mode, changes to cfg_spd10, cfg_half and cfg_fc_off have no effect on speed_10, full_dpx or the pause enables.
- R6: In mode 2'b10, link_up is 0 and no PHY access is issued.
- R7: In mode 2'b11, link_up is 1 and no PHY access is issued. The static bits drive the outputs: cfg_spd10=1 gives speed_10=1 (10 Mb/s), cfg_half=1 gives full_dpx=0, and cfg_fc_off=1 gives pause_rx_en=0.
- R8: pause_tx_en equals pause_rx_en when cfg_asym is 0, and is 0 when cfg_asym is 1.
- R9: When a poll finds a link status different from the held one, irq is set and irq_up takes the new status. Mode changes that force the link up or down never set irq.
- R10: A one-cycle pulse on irq_clr clears irq.
- R11: mdio_req stays high, with mdio_reg, mdio_we and mdio_wdata held stable, until mdio_ack arrives. mdio_req is low in the cycle after the acknowledge.
- R12: If cfg_mode changes while an access is in flight, that access is held until it is acknowledged. Its result is then discarded and the sequence for the new mode starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Link mode: 00 hardware negotiation, 01 poll only, 10 forced down, 11 forced up |
| cfg_spd10 | input | 1 | Static speed, 1 = 10 Mb/s, 0 = 100 Mb/s |
| cfg_half | input | 1 | Static duplex, 1 = half, 0 = full |
| cfg_fc_off | input | 1 | Static flow control, 1 = off, 0 = on |
| cfg_asym | input | 1 | 1 = never send pause frames |
| mdio_req | output | 1 | PHY register access request |
| mdio_we | output | 1 | 1 = write access |
| mdio_reg | output | 5 | PHY register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion pulse |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| link_up | output | 1 | Resolved link state |
| speed_10 | output | 1 | 1 = 10 Mb/s, 0 = 100 Mb/s |
| full_dpx | output | 1 | 1 = full duplex |
| pause_rx_en | output | 1 | Honour received pause frames |
| pause_tx_en | output | 1 | Allowed to send pause frames |
| irq | output | 1 | Sticky link-change interrupt |
| irq_up | output | 1 | 1 = last event was link-up |
| irq_clr | input | 1 | Write-one-to-clear for irq |

## Verification
Negotiation is driven with partner-ability words that offer 100 full with pause, then 100 half together with 10 full, then only 10 half. This separates the priority order and shows that pause is gated by both sides. A latched-but-recovered drop is played against a real drop, which shows that only the second status read counts. The static bits are changed in poll-only mode and again in forced-up mode: the outputs stay put in the first case and follow the bits in the second. A mode switch is made during a deliberately slow access, which shows that the access is held to completion and that the sequencer then goes quiet.

// File: rtl/plc_pkg.sv
package plc_pkg;

    localparam int MDIO_DW  = 16;
    localparam int MDIO_AW  = 5;
    localparam int LINK_BIT = 2;
    localparam int PAUSE_BIT = 10;

    localparam logic [MDIO_AW-1:0] REG_CTRL = 5'd0;
    localparam logic [MDIO_AW-1:0] REG_STAT = 5'd1;
    localparam logic [MDIO_AW-1:0] REG_ADV  = 5'd4;
    localparam logic [MDIO_AW-1:0] REG_LPA  = 5'd5;

    localparam logic [MDIO_DW-1:0] CTRL_RESTART = 16'h1200;
    localparam logic [MDIO_DW-1:0] ADV_BASE     = 16'h01E1;

    typedef enum logic [1:0] {
        MODE_HWNEG = 2'b00,
        MODE_POLL  = 2'b01,
        MODE_DOWN  = 2'b10,
        MODE_UP    = 2'b11
    } lmode_e;

    typedef enum logic [2:0] {
        ST_HOLD, ST_START, ST_GAP, ST_BUSY, ST_WAIT
    } seq_st_e;

    typedef enum logic [2:0] {
        STP_ADV, STP_CTL, STP_RD1A, STP_RD1B, STP_RD5
    } step_e;

    typedef struct packed {
        logic spd10;
        logic half;
        logic fc_on;
    } lcfg_t;

    typedef struct packed {
        seq_st_e state;
        step_e   step;
        lmode_e  mode;
        logic    adv_pause;
    } seq_t;

    typedef struct packed {
        logic  link;
        lcfg_t cfg;
    } lstate_t;

    typedef struct packed {
        logic flag;
        logic up;
    } irq_t;

    // Pick the best mode shared with the partner; our side offers all four.
    function automatic lcfg_t resolve_lpa(input logic [MDIO_DW-1:0] lpa, input logic adv_pause);
        lcfg_t r;
        if (lpa[8]) begin
            r.spd10 = 1'b0; r.half = 1'b0;
        end else if (lpa[7]) begin
            r.spd10 = 1'b0; r.half = 1'b1;
        end else if (lpa[6]) begin
            r.spd10 = 1'b1; r.half = 1'b0;
        end else begin
            r.spd10 = 1'b1; r.half = 1'b1;
        end
        r.fc_on = adv_pause & lpa[PAUSE_BIT];
        return r;
    endfunction

endpackage

// File: rtl/plc_poll_timer.sv
module plc_poll_timer #(
    parameter int POLL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(POLL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            done  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/plc_mdio_seq.sv
module plc_mdio_seq
    import plc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_fc_off,
    input  logic               tmr_done,
    output logic               tmr_run,
    output logic               mdio_req,
    output logic               mdio_we,
    output logic [MDIO_AW-1:0] mdio_reg,
    output logic [MDIO_DW-1:0] mdio_wdata,
    input  logic               mdio_ack,
    input  logic [MDIO_DW-1:0] mdio_rdata,
    output lmode_e             mode,
    output logic               adv_pause,
    output logic               poll_vld,
    output logic               poll_link,
    output logic               lpa_vld
);
    localparam seq_t SEQ_RST = '{state: ST_HOLD, step: STP_RD1A, mode: MODE_DOWN, adv_pause: 1'b0};

    seq_t seq_d, seq_q;
    logic mode_chg;

    always_comb begin
        seq_d    = seq_q;
        poll_vld = 1'b0;
        lpa_vld  = 1'b0;
        mode_chg = (lmode_e'(cfg_mode) != seq_q.mode);

        case (seq_q.state)
            ST_BUSY: begin
                if (mdio_ack) begin
                    if (mode_chg) begin
                        seq_d.state = ST_START;
                        seq_d.mode  = lmode_e'(cfg_mode);
                    end else begin
                        case (seq_q.step)
                            STP_ADV: begin
                                seq_d.state = ST_GAP;
                                seq_d.step  = STP_CTL;
                            end
                            STP_CTL: begin
                                seq_d.state = ST_GAP;
                                seq_d.step  = STP_RD1A;
                            end
                            STP_RD1A: begin
                                seq_d.state = ST_GAP;
                                seq_d.step  = STP_RD1B;
                            end
                            STP_RD1B: begin
                                poll_vld = 1'b1;
                                if (seq_q.mode == MODE_HWNEG && mdio_rdata[LINK_BIT]) begin
                                    seq_d.state = ST_GAP;
                                    seq_d.step  = STP_RD5;
                                end else begin
                                    seq_d.state = ST_WAIT;
                                end
                            end
                            default: begin
                                lpa_vld     = 1'b1;
                                seq_d.state = ST_WAIT;
                            end
                        endcase
                    end
                end
            end
            default: begin
                if (mode_chg) begin
                    seq_d.state = ST_START;
                    seq_d.mode  = lmode_e'(cfg_mode);
                end else begin
                    case (seq_q.state)
                        ST_START: begin
                            case (seq_q.mode)
                                MODE_HWNEG: begin
                                    seq_d.state     = ST_BUSY;
                                    seq_d.step      = STP_ADV;
                                    seq_d.adv_pause = ~cfg_fc_off;
                                end
                                MODE_POLL: begin
                                    seq_d.state = ST_BUSY;
                                    seq_d.step  = STP_RD1A;
                                end
                                default: seq_d.state = ST_HOLD;
                            endcase
                        end
                        ST_GAP:  seq_d.state = ST_BUSY;
                        ST_WAIT: begin
                            if (tmr_done) begin
                                seq_d.state = ST_GAP;
                                seq_d.step  = STP_RD1A;
                            end
                        end
                        default: seq_d.state = seq_q.state;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    always_comb begin
        logic [MDIO_DW-1:0] adv;
        adv            = ADV_BASE;
        adv[PAUSE_BIT] = seq_q.adv_pause;
        mdio_req   = (seq_q.state == ST_BUSY);
        mdio_we    = (seq_q.step == STP_ADV) || (seq_q.step == STP_CTL);
        case (seq_q.step)
            STP_ADV: begin mdio_reg = REG_ADV;  mdio_wdata = adv;          end
            STP_CTL: begin mdio_reg = REG_CTRL; mdio_wdata = CTRL_RESTART; end
            STP_RD5: begin mdio_reg = REG_LPA;  mdio_wdata = '0;           end
            default: begin mdio_reg = REG_STAT; mdio_wdata = '0;           end
        endcase
    end

    assign tmr_run   = (seq_q.state == ST_WAIT);
    assign mode      = seq_q.mode;
    assign adv_pause = seq_q.adv_pause;
    assign poll_link = mdio_rdata[LINK_BIT];

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_reg) && $stable(mdio_we) && $stable(mdio_wdata)));

    p_gap_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_ack) |=> !mdio_req);

    p_poll_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && seq_q.mode == MODE_POLL) |-> (!mdio_we && mdio_reg == REG_STAT));

    p_forced_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode[1] && !mdio_req) |=> !mdio_req);

endmodule

// File: rtl/plc_link_state.sv
module plc_link_state
    import plc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  lmode_e             mode,
    input  logic               cfg_spd10,
    input  logic               cfg_half,
    input  logic               cfg_fc_off,
    input  logic               cfg_asym,
    input  logic               adv_pause,
    input  logic               poll_vld,
    input  logic               poll_link,
    input  logic               lpa_vld,
    input  logic [MDIO_DW-1:0] lpa_word,
    output logic               chg_evt,
    output logic               link_up,
    output logic               speed_10,
    output logic               full_dpx,
    output logic               pause_rx_en,
    output logic               pause_tx_en
);
    localparam lstate_t LS_RST = '{link: 1'b0, cfg: '{spd10: 1'b0, half: 1'b0, fc_on: 1'b0}};

    lstate_t ls_d, ls_q;

    always_comb begin
        ls_d    = ls_q;
        chg_evt = 1'b0;
        case (mode)
            MODE_DOWN: ls_d.link = 1'b0;
            MODE_UP: begin
                ls_d.link      = 1'b1;
                ls_d.cfg.spd10 = cfg_spd10;
                ls_d.cfg.half  = cfg_half;
                ls_d.cfg.fc_on = ~cfg_fc_off;
            end
            default: begin
                if (poll_vld) begin
                    ls_d.link = poll_link;
                    chg_evt   = (poll_link != ls_q.link);
                end
                if (lpa_vld && mode == MODE_HWNEG) begin
                    ls_d.cfg = resolve_lpa(lpa_word, adv_pause);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ls_q <= LS_RST;
        else        ls_q <= ls_d;
    end

    assign link_up     = ls_q.link;
    assign speed_10    = ls_q.cfg.spd10;
    assign full_dpx    = ~ls_q.cfg.half;
    assign pause_rx_en = ls_q.cfg.fc_on;
    assign pause_tx_en = ls_q.cfg.fc_on & ~cfg_asym;

    p_poll_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_POLL && !lpa_vld) |=> $stable(ls_q.cfg));

endmodule

// File: rtl/plc_link_irq.sv
module plc_link_irq
    import plc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic evt_up,
    input  logic clr,
    output logic irq,
    output logic irq_up
);
    irq_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.flag = (irq_q.flag & ~clr) | evt;
        if (evt) irq_d.up = evt_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq    = irq_q.flag;
    assign irq_up = irq_q.up;

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !irq);

endmodule

// File: rtl/phy_link_ctl.sv
module phy_link_ctl
    import plc_pkg::*;
#(
    parameter int POLL_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_mode,
    input  logic        cfg_spd10,
    input  logic        cfg_half,
    input  logic        cfg_fc_off,
    input  logic        cfg_asym,
    output logic        mdio_req,
    output logic        mdio_we,
    output logic [4:0]  mdio_reg,
    output logic [15:0] mdio_wdata,
    input  logic        mdio_ack,
    input  logic [15:0] mdio_rdata,
    output logic        link_up,
    output logic        speed_10,
    output logic        full_dpx,
    output logic        pause_rx_en,
    output logic        pause_tx_en,
    output logic        irq,
    output logic        irq_up,
    input  logic        irq_clr
);
    logic   tmr_run, tmr_done;
    lmode_e mode;
    logic   adv_pause, poll_vld, poll_link, lpa_vld, chg_evt;

    plc_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .done(tmr_done)
    );

    plc_mdio_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_fc_off(cfg_fc_off),
        .tmr_done(tmr_done), .tmr_run(tmr_run),
        .mdio_req(mdio_req), .mdio_we(mdio_we), .mdio_reg(mdio_reg),
        .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
        .mode(mode), .adv_pause(adv_pause),
        .poll_vld(poll_vld), .poll_link(poll_link), .lpa_vld(lpa_vld)
    );

    plc_link_state u_state (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .cfg_spd10(cfg_spd10), .cfg_half(cfg_half),
        .cfg_fc_off(cfg_fc_off), .cfg_asym(cfg_asym),
        .adv_pause(adv_pause), .poll_vld(poll_vld), .poll_link(poll_link),
        .lpa_vld(lpa_vld), .lpa_word(mdio_rdata), .chg_evt(chg_evt),
        .link_up(link_up), .speed_10(speed_10), .full_dpx(full_dpx),
        .pause_rx_en(pause_rx_en), .pause_tx_en(pause_tx_en)
    );

    plc_link_irq u_irq (
        .clk(clk), .rst_n(rst_n), .evt(chg_evt), .evt_up(poll_link),
        .clr(irq_clr), .irq(irq), .irq_up(irq_up)
    );

    p_irq_tracks_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((link_up != $past(link_up)) && (irq_up == link_up)));

    p_forced_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP && $past(mode) == MODE_UP) |-> link_up);

endmodule

// File: tb/phy_link_ctl_tb.sv
module phy_link_ctl_tb_top;
    localparam int POLL = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b10;
    logic cfg_spd10 = 1'b0, cfg_half = 1'b0, cfg_fc_off = 1'b0, cfg_asym = 1'b0;
    logic mdio_req, mdio_we, mdio_ack = 1'b0;
    logic [4:0]  mdio_reg;
    logic [15:0] mdio_wdata, mdio_rdata = '0;
    logic link_up, speed_10, full_dpx, pause_rx_en, pause_tx_en, irq, irq_up;
    logic irq_clr = 1'b0;

    int checks = 0, errors = 0;
    // PHY model state
    logic phy_link = 1'b0, phy_latched = 1'b0;
    logic [15:0] partner = '0;
    int ack_dly = 1, ack_cnt = 0;
    int req_count = 0, wr_count = 0, rd1_count = 0, rd5_count = 0;
    logic [4:0]  wlog_reg [4];
    logic [15:0] wlog_dat [4];

    always #5 clk = ~clk;

    phy_link_ctl #(.POLL_CYCLES(POLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_spd10(cfg_spd10),
        .cfg_half(cfg_half), .cfg_fc_off(cfg_fc_off), .cfg_asym(cfg_asym),
        .mdio_req(mdio_req), .mdio_we(mdio_we), .mdio_reg(mdio_reg),
        .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
        .link_up(link_up), .speed_10(speed_10), .full_dpx(full_dpx),
        .pause_rx_en(pause_rx_en), .pause_tx_en(pause_tx_en),
        .irq(irq), .irq_up(irq_up), .irq_clr(irq_clr)
    );

    // PHY responder
    initial begin
        forever begin
            @(posedge clk);
            mdio_ack <= 1'b0;
            if (mdio_req && !mdio_ack) begin
                if (ack_cnt >= ack_dly) begin
                    ack_cnt  <= 0;
                    mdio_ack <= 1'b1;
                    req_count <= req_count + 1;
                    if (mdio_we) begin
                        if (wr_count < 4) begin
                            wlog_reg[wr_count] <= mdio_reg;
                            wlog_dat[wr_count] <= mdio_wdata;
                        end
                        wr_count <= wr_count + 1;
                    end else if (mdio_reg == 5'd1) begin
                        mdio_rdata  <= {13'b0, phy_link & ~phy_latched, 2'b0};
                        phy_latched <= 1'b0;
                        rd1_count   <= rd1_count + 1;
                    end else if (mdio_reg == 5'd5) begin
                        mdio_rdata <= partner;
                        rd5_count  <= rd5_count + 1;
                    end
                end else begin
                    ack_cnt <= ack_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        wait_n(3);
        chk("R1 link_up", link_up, 0);
        chk("R1 irq", {irq, irq_up}, 0);
        chk("R1 mdio_req", mdio_req, 0);
        chk("R1 speed/duplex", {speed_10, full_dpx}, 2'b01);
        chk("R1 pause", {pause_rx_en, pause_tx_en}, 0);
    endtask

    task automatic t_hwneg();
        partner  = 16'h0501;
        phy_link = 1'b1;
        cfg_mode = 2'b00;
        wait_n(200);
        chk("R2 first write reg", wlog_reg[0], 5'd4);
        chk("R2 adv word", wlog_dat[0], 16'h05E1);
        chk("R2 second write reg", wlog_reg[1], 5'd0);
        chk("R2 ctrl word", wlog_dat[1], 16'h1200);
        chk("R2 writes only once", wr_count, 2);
        chk("R3 link up", link_up, 1);
        chk("R4 100 full pause", {speed_10, full_dpx, pause_rx_en, pause_tx_en}, 4'b0111);
        chk("R9 irq on up", {irq, irq_up}, 2'b11);
        clear_irq();
        chk("R10 irq cleared", irq, 0);
        partner = 16'h00C1;
        wait_n(150);
        chk("R4 100 half beats 10 full", {speed_10, full_dpx, pause_rx_en}, 3'b000);
        partner = 16'h0021;
        wait_n(150);
        chk("R4 10 half only", {speed_10, full_dpx, pause_rx_en}, 3'b100);
        chk("R9 no irq without link change", irq, 0);
    endtask

    task automatic t_latch();
        phy_latched = 1'b1;
        wait_n(150);
        chk("R3 recovered drop ignored", {link_up, irq}, 2'b10);
        phy_link = 1'b0; phy_latched = 1'b1;
        wait_n(150);
        chk("R3 real drop", link_up, 0);
        chk("R9 irq on down", {irq, irq_up}, 2'b10);
        clear_irq();
        phy_link = 1'b1;
        wait_n(150);
        clear_irq();
    endtask

    task automatic t_poll_only();
        int w0, r5, r1;
        logic [3:0] outs;
        cfg_mode = 2'b01;
        wait_n(50);
        w0 = wr_count; r5 = rd5_count;
        outs = {speed_10, full_dpx, pause_rx_en, pause_tx_en};
        cfg_spd10 = 1'b0; cfg_half = 1'b0; cfg_fc_off = 1'b0;
        wait_n(150);
        chk("R5 static bits ignored", {speed_10, full_dpx, pause_rx_en, pause_tx_en}, outs);
        chk("R5 no writes", wr_count, w0);
        chk("R5 no partner reads", rd5_count, r5);
        phy_link = 1'b0; phy_latched = 1'b1;
        wait_n(150);
        chk("R9 poll-only down event", {link_up, irq, irq_up}, 3'b010);
        clear_irq();
        phy_link = 1'b1;
        wait_n(150);
        chk("R9 poll-only up event", {link_up, irq, irq_up}, 3'b111);
        clear_irq();
        r1 = rd1_count;
        wait_n(560);
        chk("R3 poll rate low bound", (rd1_count - r1) >= 28, 1);
        chk("R3 poll rate high bound", (rd1_count - r1) <= 56, 1);
    endtask

    task automatic t_forced();
        int rc;
        cfg_mode = 2'b10;
        wait_n(50);
        chk("R6 forced down", link_up, 0);
        chk("R9 no irq on forced", irq, 0);
        rc = req_count;
        wait_n(100);
        chk("R6 no access", req_count, rc);
        cfg_spd10 = 1'b1; cfg_half = 1'b1; cfg_fc_off = 1'b0; cfg_asym = 1'b1;
        cfg_mode = 2'b11;
        wait_n(20);
        chk("R7 forced up", {link_up, speed_10, full_dpx, pause_rx_en}, 4'b1101);
        chk("R8 asym blocks tx pause", pause_tx_en, 0);
        chk("R9 no irq on forced up", irq, 0);
        cfg_asym = 1'b0;
        wait_n(2);
        chk("R8 tx pause normal", pause_tx_en, 1);
        cfg_fc_off = 1'b1; cfg_spd10 = 1'b0; cfg_half = 1'b0;
        wait_n(5);
        chk("R7 follows static bits", {speed_10, full_dpx, pause_rx_en, pause_tx_en}, 4'b0100);
        wait_n(100);
        chk("R7 no access", req_count, rc);
    endtask

    task automatic t_abort();
        int rc, guard;
        logic [4:0] reg0;
        ack_dly  = 30;
        cfg_mode = 2'b01;
        guard = 0;
        while (!mdio_req && guard < 200) begin @(negedge clk); guard++; end
        chk("R12 access started", mdio_req, 1);
        reg0 = mdio_reg;
        cfg_mode = 2'b10;
        wait_n(10);
        chk("R12 in-flight held", mdio_req, 1);
        chk("R11 address stable", mdio_reg, reg0);
        wait_n(40);
        chk("R12 quiet after abort", mdio_req, 0);
        chk("R12 new mode applied", link_up, 0);
        rc = req_count;
        wait_n(100);
        chk("R12 no further access", req_count, rc);
        ack_dly = 1;
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        t_reset();
        t_hwneg();
        t_latch();
        t_poll_only();
        t_forced();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule